// File: doc/BRIEF.md
# Fragmenting Receive DMA Request Controller

This block paces the DMA requests that empty the receive FIFO of a serial channel into memory buffers of bounded size. Once software arms it with a receive-enable command, it asks the external DMA engine for one block of bytes each time the FIFO holds a full block. When the bytes written into the current buffer reach the programmed buffer limit, it stops requesting and raises a buffer-full interrupt. Software then supplies a new buffer and issues the command again, so one frame can be split across several buffers.

When the end of a frame has been marked, the block keeps requesting until the FIFO is empty. The last request covers a partial block, and that block ends with the receive status byte. It then raises a transfer-end interrupt. A running byte count, which includes the status byte and is split into a low and a high half, tells software how long the frame was.

States: IDLE (not armed, or frame finished), WAIT (armed, waiting for data), BURST (requesting one full block), FINAL (requesting the frame tail), PAUSE (buffer full, waiting for the re-arm command).

Transitions:
- IDLE to WAIT on the command.
- WAIT to BURST when the level reaches the block size.
- WAIT to FINAL when the frame end has been seen and fewer than a block remain.
- BURST to WAIT at the end of a block.
- BURST or FINAL to IDLE when the last byte of the frame moves.
- BURST or FINAL to PAUSE when the buffer fills.
- PAUSE to WAIT on the command.

Top module: `rxdma_frag_ctrl`

## Requirements
- R1: After reset, dma_req, irq_rbf and irq_rdte are 0 and the byte count is 0.
- R2: dma_req is never raised before a receive-enable command has armed the block. Once armed, it rises only when fifo_level reaches the block size or a frame end has been seen. The block size is 4 << cfg_blk_code, so codes 0..3 give 4, 8, 16 and 32 bytes.
- R3: A full-block request stays high for exactly one block of accepted transfers and then drops, even if more bytes remain in the FIFO.
- R4: When the bytes accepted into the current buffer reach cfg_max_buf, dma_req drops and irq_rbf is set. No further request is made until the next receive-enable command, however full the FIFO becomes.
- R5: A receive-enable command in the paused state loads the new buffer limit and resumes requests.
- R6: After a frame-end mark, requests continue until the FIFO is empty, including the status byte. When the last byte is accepted, irq_rdte is set.
- R7: The byte count {cnt_hi, cnt_lo} counts every accepted byte, including the status byte. It is not cleared by a re-arm within a frame. It is cleared by the command that starts a new frame.
- R8: If the buffer limit and the frame's last byte fall on the same transfer, irq_rdte is set and irq_rbf is not.
- R9: Both interrupt flags are sticky. Writing a 1 to irq_clr bit 0 clears irq_rbf, and writing a 1 to bit 1 clears irq_rdte. A 0 in a bit leaves that flag unchanged.
- R10: A receive-enable command while a request is active is ignored. A dma_xfer pulse while dma_req is low is ignored, and the byte count does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| fifo_level | input | LVL_W | Bytes currently held in the receive FIFO |
| eof_mark | input | 1 | Pulse: the status byte closing a frame entered the FIFO |
| dma_xfer | input | 1 | One byte moved by the DMA engine this cycle |
| cmd_rx_en | input | 1 | Receive-enable command strobe |
| cfg_max_buf | input | BUF_W | Buffer limit in bytes, taken at the command |
| cfg_blk_code | input | CODE_W | Block size code, taken at the command |
| irq_clr | input | 2 | Write-one-to-clear: bit 0 buffer full, bit 1 transfer end |
| dma_req | output | 1 | DMA request |
| irq_rbf | output | 1 | Buffer-full interrupt flag |
| irq_rdte | output | 1 | Transfer-end interrupt flag |
| cnt_lo | output | CNT_W/2 | Byte count, low half |
| cnt_hi | output | CNT_W/2 | Byte count, high half |

## Verification
The hardest situation to reach is the pause in the middle of a frame. While paused, the FIFO keeps filling, dma_xfer pulses arrive without a request, and only then does a re-arm let the frame finish with a partial block. The bench reaches it with a 199-byte frame fed at one byte per cycle into 128-byte buffers. A DMA model drains the FIFO concurrently, and the bench checks the count before and after the re-arm. The case where the buffer limit and the frame's last byte coincide is reached with a 16-byte frame into a 16-byte buffer.

// File: rtl/rxdma_pkg.sv
package rxdma_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WAIT,
        ST_BURST,
        ST_FINAL,
        ST_PAUSE
    } rx_state_e;
endpackage

// File: rtl/rxdma_counters.sv
module rxdma_counters #(
    parameter int LVL_W    = 8,
    parameter int BUF_W    = 16,
    parameter int CNT_W    = 16,
    parameter int CODE_W   = 2,
    parameter int MIN_BLK  = 4,
    parameter int DEF_CODE = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              frame_start,
    input  logic              rearm,
    input  logic              xfer,
    input  logic              clr_blk,
    input  logic [BUF_W-1:0]  cfg_max_buf,
    input  logic [CODE_W-1:0] cfg_blk_code,
    output logic [LVL_W-1:0]  blk_size,
    output logic              blk_last,
    output logic              buf_last,
    output logic [CNT_W-1:0]  byte_cnt
);
    logic [BUF_W-1:0]  max_q;
    logic [BUF_W-1:0]  buf_cnt;
    logic [LVL_W-1:0]  blk_cnt;
    logic [CODE_W-1:0] code_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            max_q   <= '0;
            code_q  <= CODE_W'(DEF_CODE);
            buf_cnt <= '0;
        end else if (frame_start || rearm) begin
            max_q   <= cfg_max_buf;
            code_q  <= cfg_blk_code;
            buf_cnt <= '0;
        end else if (xfer) begin
            buf_cnt <= buf_cnt + BUF_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            byte_cnt <= '0;
        end else if (frame_start) begin
            byte_cnt <= '0;
        end else if (xfer) begin
            byte_cnt <= byte_cnt + CNT_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            blk_cnt <= '0;
        end else if (clr_blk) begin
            blk_cnt <= '0;
        end else if (xfer) begin
            blk_cnt <= blk_cnt + LVL_W'(1);
        end
    end

    assign blk_size = LVL_W'(MIN_BLK) << code_q;
    assign blk_last = (blk_cnt == blk_size - LVL_W'(1));
    assign buf_last = (buf_cnt == max_q - BUF_W'(1));
endmodule

// File: rtl/rxdma_fsm.sv
module rxdma_fsm
    import rxdma_pkg::*;
#(
    parameter int LVL_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd_rx_en,
    input  logic [LVL_W-1:0] fifo_level,
    input  logic [LVL_W-1:0] blk_size,
    input  logic             eof_mark,
    input  logic             dma_xfer,
    input  logic             blk_last,
    input  logic             buf_last,
    output rx_state_e        st,
    output logic             dma_req,
    output logic             xfer,
    output logic             frame_start,
    output logic             rearm,
    output logic             ev_full,
    output logic             ev_done,
    output logic             clr_blk
);
    rx_state_e st_nx;
    logic      eof_seen;
    logic      eof_now;
    logic      last_byte;
    logic      blk_end;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st <= ST_IDLE;
        end else begin
            st <= st_nx;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            eof_seen <= 1'b0;
        end else if (eof_mark) begin
            eof_seen <= 1'b1;
        end else if (frame_start || ev_done) begin
            eof_seen <= 1'b0;
        end
    end

    // outputs and events
    always_comb begin
        dma_req     = (st == ST_BURST) || (st == ST_FINAL);
        xfer        = dma_req && dma_xfer;
        eof_now     = eof_seen || eof_mark;
        last_byte   = eof_now && (fifo_level == LVL_W'(1));
        ev_done     = xfer && last_byte;
        ev_full     = xfer && buf_last && !ev_done;
        blk_end     = xfer && (st == ST_BURST) && blk_last;
        frame_start = (st == ST_IDLE) && cmd_rx_en;
        rearm       = (st == ST_PAUSE) && cmd_rx_en;
        clr_blk     = (st != ST_BURST);
    end

    // next state
    always_comb begin
        st_nx = st;
        unique case (st)
            ST_IDLE: begin
                if (cmd_rx_en) st_nx = ST_WAIT;
            end
            ST_WAIT: begin
                if (fifo_level >= blk_size)                 st_nx = ST_BURST;
                else if (eof_now && fifo_level != '0)       st_nx = ST_FINAL;
            end
            ST_BURST: begin
                if (ev_done)       st_nx = ST_IDLE;
                else if (ev_full)  st_nx = ST_PAUSE;
                else if (blk_end)  st_nx = ST_WAIT;
            end
            ST_FINAL: begin
                if (ev_done)       st_nx = ST_IDLE;
                else if (ev_full)  st_nx = ST_PAUSE;
            end
            ST_PAUSE: begin
                if (cmd_rx_en) st_nx = ST_WAIT;
            end
            default: st_nx = ST_IDLE;
        endcase
    end
endmodule

// File: rtl/rxdma_irq.sv
module rxdma_irq (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       set_rbf,
    input  logic       set_rdte,
    input  logic [1:0] irq_clr,
    output logic       irq_rbf,
    output logic       irq_rdte
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            irq_rbf  <= 1'b0;
            irq_rdte <= 1'b0;
        end else begin
            if (set_rbf)         irq_rbf <= 1'b1;
            else if (irq_clr[0]) irq_rbf <= 1'b0;
            if (set_rdte)        irq_rdte <= 1'b1;
            else if (irq_clr[1]) irq_rdte <= 1'b0;
        end
    end
endmodule

// File: rtl/rxdma_frag_ctrl.sv
module rxdma_frag_ctrl
    import rxdma_pkg::*;
#(
    parameter int LVL_W    = 8,
    parameter int BUF_W    = 16,
    parameter int CNT_W    = 16,
    parameter int CODE_W   = 2,
    parameter int MIN_BLK  = 4,
    parameter int DEF_CODE = 3
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [LVL_W-1:0]     fifo_level,
    input  logic                 eof_mark,
    input  logic                 dma_xfer,
    input  logic                 cmd_rx_en,
    input  logic [BUF_W-1:0]     cfg_max_buf,
    input  logic [CODE_W-1:0]    cfg_blk_code,
    input  logic [1:0]           irq_clr,
    output logic                 dma_req,
    output logic                 irq_rbf,
    output logic                 irq_rdte,
    output logic [CNT_W/2-1:0]   cnt_lo,
    output logic [CNT_W/2-1:0]   cnt_hi
);
    localparam int HALF = CNT_W / 2;

    rx_state_e        st;
    logic             xfer;
    logic             frame_start;
    logic             rearm;
    logic             ev_full;
    logic             ev_done;
    logic             clr_blk;
    logic             blk_last;
    logic             buf_last;
    logic [LVL_W-1:0] blk_size;
    logic [CNT_W-1:0] byte_cnt;

    rxdma_fsm #(.LVL_W(LVL_W)) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .cmd_rx_en   (cmd_rx_en),
        .fifo_level  (fifo_level),
        .blk_size    (blk_size),
        .eof_mark    (eof_mark),
        .dma_xfer    (dma_xfer),
        .blk_last    (blk_last),
        .buf_last    (buf_last),
        .st          (st),
        .dma_req     (dma_req),
        .xfer        (xfer),
        .frame_start (frame_start),
        .rearm       (rearm),
        .ev_full     (ev_full),
        .ev_done     (ev_done),
        .clr_blk     (clr_blk)
    );

    rxdma_counters #(
        .LVL_W(LVL_W), .BUF_W(BUF_W), .CNT_W(CNT_W),
        .CODE_W(CODE_W), .MIN_BLK(MIN_BLK), .DEF_CODE(DEF_CODE)
    ) u_cnt (
        .clk          (clk),
        .rst_n        (rst_n),
        .frame_start  (frame_start),
        .rearm        (rearm),
        .xfer         (xfer),
        .clr_blk      (clr_blk),
        .cfg_max_buf  (cfg_max_buf),
        .cfg_blk_code (cfg_blk_code),
        .blk_size     (blk_size),
        .blk_last     (blk_last),
        .buf_last     (buf_last),
        .byte_cnt     (byte_cnt)
    );

    rxdma_irq u_irq (
        .clk      (clk),
        .rst_n    (rst_n),
        .set_rbf  (ev_full),
        .set_rdte (ev_done),
        .irq_clr  (irq_clr),
        .irq_rbf  (irq_rbf),
        .irq_rdte (irq_rdte)
    );

    assign cnt_lo = byte_cnt[HALF-1:0];
    assign cnt_hi = byte_cnt[CNT_W-1:HALF];
endmodule

// File: rtl/rxdma_frag_checker.sv
module rxdma_frag_checker
    import rxdma_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             dma_req,
    input logic             dma_xfer,
    input logic             cmd_rx_en,
    input logic             irq_rbf,
    input logic             irq_rdte,
    input logic [1:0]       irq_clr,
    input logic [CNT_W-1:0] byte_cnt,
    input rx_state_e        st
);
    AST_NO_REQ_UNARMED: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_IDLE && !cmd_rx_en) |=> !dma_req); // R2

    AST_FULL_DROPS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_rbf) |-> !dma_req); // R4

    AST_PAUSE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_PAUSE && !cmd_rx_en) |=> (st == ST_PAUSE && !dma_req)); // R4

    AST_DONE_DROPS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_rdte) |-> !dma_req); // R6

    AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (dma_req && dma_xfer) |=> (byte_cnt == $past(byte_cnt) + CNT_W'(1))); // R7

    AST_DONE_OVER_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_rdte) |-> !$rose(irq_rbf)); // R8

    AST_RDTE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_rdte && !irq_clr[1]) |=> irq_rdte); // R9

    AST_RBF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_rbf && !irq_clr[0]) |=> irq_rbf); // R9
endmodule

bind rxdma_frag_ctrl rxdma_frag_checker #(.CNT_W(CNT_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .dma_req   (dma_req),
    .dma_xfer  (dma_xfer),
    .cmd_rx_en (cmd_rx_en),
    .irq_rbf   (irq_rbf),
    .irq_rdte  (irq_rdte),
    .irq_clr   (irq_clr),
    .byte_cnt  (byte_cnt),
    .st        (st)
);

// File: tb/rxdma_frag_ctrl_bench.sv
module rxdma_frag_ctrl_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  fifo_level = '0;
    logic        eof_mark = 1'b0;
    logic        dma_xfer = 1'b0;
    logic        cmd_rx_en = 1'b0;
    logic [15:0] cfg_max_buf = '0;
    logic [1:0]  cfg_blk_code = '0;
    logic [1:0]  irq_clr = '0;
    logic        dma_req;
    logic        irq_rbf;
    logic        irq_rdte;
    logic [7:0]  cnt_lo;
    logic [7:0]  cnt_hi;

    int  vectors = 0;
    int  miscomp = 0;
    int  lvl = 0;
    int  pay_left = 0;
    bit  stat_pend = 1'b0;
    bit  force_xfer = 1'b0;
    bit  taken = 1'b0;
    int  moved = 0;

    always #4 clk = ~clk;

    rxdma_frag_ctrl u_rxdma_frag_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .fifo_level   (fifo_level),
        .eof_mark     (eof_mark),
        .dma_xfer     (dma_xfer),
        .cmd_rx_en    (cmd_rx_en),
        .cfg_max_buf  (cfg_max_buf),
        .cfg_blk_code (cfg_blk_code),
        .irq_clr      (irq_clr),
        .dma_req      (dma_req),
        .irq_rbf      (irq_rbf),
        .irq_rdte     (irq_rdte),
        .cnt_lo       (cnt_lo),
        .cnt_hi       (cnt_hi)
    );

    // FIFO and DMA engine model, updated at each falling edge
    initial begin
        forever begin
            @(negedge clk);
            if (taken) begin
                lvl   = lvl - 1;
                moved = moved + 1;
            end
            eof_mark = 1'b0;
            if (pay_left > 0) begin
                lvl      = lvl + 1;
                pay_left = pay_left - 1;
            end else if (stat_pend) begin
                lvl       = lvl + 1;
                stat_pend = 1'b0;
                eof_mark  = 1'b1;
            end
            fifo_level = 8'(lvl);
            dma_xfer   = force_xfer || (dma_req && lvl > 0);
            taken      = dma_xfer && dma_req;
        end
    end

    task automatic chk(string tag, int act, int exp);
        vectors++;
        if (act != exp) begin
            miscomp++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    function automatic int count_now();
        return {cnt_hi, cnt_lo};
    endfunction

    task automatic do_reset();
        @(negedge clk);
        rst_n      = 1'b0;
        pay_left   = 0;
        stat_pend  = 1'b0;
        force_xfer = 1'b0;
        cmd_rx_en  = 1'b0;
        irq_clr    = '0;
        repeat (3) @(negedge clk);
        lvl   = 0;
        moved = 0;
        taken = 1'b0;
        #1 rst_n = 1'b1;
        @(negedge clk);
        lvl   = 0;
        moved = 0;
    endtask

    task automatic arm(int max_buf, int code);
        @(negedge clk);
        #1;
        cfg_max_buf  = 16'(max_buf);
        cfg_blk_code = 2'(code);
        cmd_rx_en    = 1'b1;
        @(negedge clk);
        #1 cmd_rx_en = 1'b0;
    endtask

    task automatic pulse_clr(logic [1:0] bits);
        @(negedge clk);
        #1 irq_clr = bits;
        @(negedge clk);
        #1 irq_clr = '0;
    endtask

    task automatic wait_rbf();
        for (int i = 0; i < 2000 && !irq_rbf; i++) @(negedge clk);
    endtask

    task automatic wait_rdte();
        for (int i = 0; i < 2000 && !irq_rdte; i++) @(negedge clk);
    endtask

    task automatic t_reset();
        do_reset();
        chk("R1 dma_req", int'(dma_req), 0);
        chk("R1 irq_rbf", int'(irq_rbf), 0);
        chk("R1 irq_rdte", int'(irq_rdte), 0);
        chk("R1 count", count_now(), 0);
    endtask

    task automatic t_unarmed();
        int hi = 0;
        do_reset();
        pay_left = 40;
        for (int i = 0; i < 60; i++) begin
            @(negedge clk);
            if (dma_req) hi++;
        end
        chk("R2 no request before arm", hi, 0);
        chk("R2 nothing moved", moved, 0);
    endtask

    task automatic t_block();
        do_reset();
        arm(1000, 1);
        pay_left = 5;
        repeat (12) @(negedge clk);
        chk("R2 below block size", int'(dma_req), 0);
        pay_left = 7;
        repeat (30) @(negedge clk);
        chk("R3 one block moved", moved, 8);
        chk("R3 request dropped", int'(dma_req), 0);
        chk("R3 left in fifo", lvl, 4);
        chk("R3 count", count_now(), 8);
    endtask

    task automatic t_frag();
        int hi = 0;
        do_reset();
        arm(128, 3);
        pay_left  = 198;
        stat_pend = 1'b1;
        for (int i = 0; i < 500 && !dma_req; i++) @(negedge clk);
        arm(16, 3); // R10 ignored while requesting
        cfg_max_buf = 16'd128;
        wait_rbf();
        chk("R4 irq_rbf", int'(irq_rbf), 1);
        chk("R4 moved at full", moved, 128);
        chk("R10 limit unchanged by command during burst", count_now(), 128);
        for (int i = 0; i < 40; i++) begin
            @(negedge clk);
            if (dma_req) hi++;
        end
        chk("R4 paused", hi, 0);
        force_xfer = 1'b1;
        repeat (5) @(negedge clk);
        force_xfer = 1'b0;
        @(negedge clk);
        chk("R10 stray xfer ignored", count_now(), 128);
        pulse_clr(2'b01);
        @(negedge clk);
        chk("R9 rbf cleared", int'(irq_rbf), 0);
        arm(128, 3);
        wait_rdte();
        chk("R6 irq_rdte", int'(irq_rdte), 1);
        chk("R6 fifo drained", lvl, 0);
        chk("R5 resumed to end", moved, 199);
        chk("R7 count lo", int'(cnt_lo), 199);
        chk("R7 count hi", int'(cnt_hi), 0);
        chk("R4 no second full", int'(irq_rbf), 0);
    endtask

    task automatic t_coinc();
        do_reset();
        arm(16, 1);
        pay_left  = 15;
        stat_pend = 1'b1;
        wait_rdte();
        @(negedge clk);
        chk("R8 rdte set", int'(irq_rdte), 1);
        chk("R8 rbf not set", int'(irq_rbf), 0);
        chk("R8 count", count_now(), 16);
        repeat (5) @(negedge clk);
        chk("R9 rdte sticky", int'(irq_rdte), 1);
        pulse_clr(2'b01);
        @(negedge clk);
        chk("R9 wrong bit keeps rdte", int'(irq_rdte), 1);
        pulse_clr(2'b10);
        @(negedge clk);
        chk("R9 rdte cleared", int'(irq_rdte), 0);
    endtask

    task automatic t_newframe();
        do_reset();
        arm(1024, 2);
        pay_left  = 299;
        stat_pend = 1'b1;
        wait_rdte();
        @(negedge clk);
        chk("R7 long count hi", int'(cnt_hi), 1);
        chk("R7 long count lo", int'(cnt_lo), 44);
        arm(1024, 2);
        @(negedge clk);
        chk("R7 cleared on new frame", count_now(), 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        miscomp++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscomp);
        $finish;
    end

    initial begin
        t_reset();
        t_unarmed();
        t_block();
        t_frag();
        t_coinc();
        t_newframe();
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscomp);
        $finish;
    end
endmodule